// File: doc/BRIEF.md
# Instruction Fetch Line Buffer for Wide Flash

This block sits between a processor's instruction-fetch port and a flash array that delivers one 256-bit line per read. It keeps a small set of line buffers. Each buffer has its own line-address tag and valid flag. Every fetch address is compared against the valid tags of the buffers that are currently enabled. On a match, the selected 32-bit word goes back to the processor in the same cycle. On a mismatch, the fetch is stalled while one buffer is invalidated and then refilled by a single line read. The read lasts a programmable number of wait states.

A run-time mode input picks how many buffers are active. With all four buffers active, the victim is the least-recently-used buffer, and usage is tracked as an age ranking. With only two buffers active, refills alternate strictly between them, so that fetch timing does not depend on the hit history.

The wait-state count is double-buffered. Software writes a pending value, and a separate strobe copies it into the active setting. A flip of the mode input discards every stored line.

Top module: `flash_prefetch_buf`

## Requirements
- R1: After reset no buffer holds a valid line, four-buffer mode is assumed, and the active wait-state count is 5. The first fetch therefore misses and takes 7 cycles. Neither `fetch_rdy` nor `flash_rd_en` is high while no fetch is pending.
- R2: A fetch whose line address (`fetch_addr[23:5]`) matches a valid, enabled buffer is answered with `fetch_rdy` high in the same cycle. `fetch_data` carries word `fetch_addr[4:2]` of the line, where word 0 is line bits 31:0 and word 7 is line bits 255:224.
- R3: On a miss, `flash_rd_en` rises in the next cycle and stays high for exactly (active wait states + 1) cycles. During that time `flash_rd_line` equals the fetch's line address. The fetch completes with `fetch_rdy` high (wait states + 2) cycles after the request cycle, with the correct word.
- R4: With four buffers active, a miss replaces the buffer that has gone longest without a hit.
- R5: With two buffers active (`cfg_two_buf`=1), each refill goes to the buffer that was not refilled last, whatever the hit history. Only those two buffers can hit.
- R6: Every hit, including the one that completes a refill, makes that buffer the most recently used.
- R7: A value written with `ws_wr` has no effect on refill timing until `ws_upd` is pulsed. If `ws_wr` and `ws_upd` are pulsed in the same cycle, the update copies the previously pending value. The new count applies to refills that start after the update.
- R8: Any change of `cfg_two_buf` invalidates every buffer at the next clock edge, so that a previously cached line misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_req | input | 1 | Fetch request, held with a stable address until `fetch_rdy` |
| fetch_addr | input | 24 | Byte address of the instruction word |
| fetch_rdy | output | 1 | Fetch completes in this cycle |
| fetch_data | output | 32 | Fetched instruction word |
| flash_rd_en | output | 1 | Line read in progress |
| flash_rd_line | output | 19 | Line address of the read |
| flash_rd_data | input | 256 | Line returned by flash, captured in the last read cycle |
| cfg_two_buf | input | 1 | 1: two buffers with alternating refill; 0: four buffers with LRU |
| ws_wr | input | 1 | Load `ws_wdata` into the pending wait-state register |
| ws_wdata | input | 4 | New wait-state count |
| ws_upd | input | 1 | Copy the pending wait-state count into the active one |

## Verification
A hit is due in the request cycle itself. A miss raises the read strobe one cycle after the request and holds it for wait states + 1 cycles, and `fetch_rdy` follows wait states + 2 cycles after the request cycle. The bench drives every input on the falling edge and samples one time unit later. It counts elapsed falling edges until `fetch_rdy`, and compares that count with the value predicted from its own model of the active wait-state setting. Replacement order, the shadowed timing register and the mode flush are observed only through these latencies: a fetch that is expected to hit must show zero latency, and one that is expected to miss must show the full refill latency.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
   typedef enum logic {
      FPB_IDLE = 1'b0,
      FPB_FILL = 1'b1
   } fpb_state_e;
endpackage

// File: rtl/fpb_ws_shadow.sv
module fpb_ws_shadow #(
   parameter int WS_W     = 4,
   parameter int WS_RESET = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ws_wr,
   input  logic [WS_W-1:0] ws_wdata,
   input  logic            ws_upd,
   output logic [WS_W-1:0] ws_act
);
   logic [WS_W-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= WS_W'(WS_RESET);
         ws_act <= WS_W'(WS_RESET);
      end else begin
         if (ws_wr)  pend_q <= ws_wdata;
         if (ws_upd) ws_act <= pend_q;
      end
   end

   assert_ws_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ws_upd |=> $stable(ws_act));
   assert_ws_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ws_upd |=> ws_act == $past(pend_q));
endmodule

// File: rtl/fpb_replace.sv
module fpb_replace #(
   parameter int NBUF       = 4,
   parameter int NBUF_SMALL = 2,
   parameter int IDX_W      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             two_mode,
   input  logic             touch,
   input  logic [IDX_W-1:0] touch_idx,
   input  logic             fill_done,
   input  logic [IDX_W-1:0] fill_idx,
   output logic [IDX_W-1:0] victim
);
   logic [IDX_W-1:0] next_q;
   logic [IDX_W-1:0] lru_idx;

   // alternating refill pointer for the small set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         next_q <= '0;
      else if (fill_done)
         next_q <= (fill_idx >= IDX_W'(NBUF_SMALL - 1)) ? '0 : fill_idx + 1'b1;
   end

   generate
      if (NBUF > NBUF_SMALL) begin : g_lru
         logic [NBUF-1:0][IDX_W-1:0] age_q;
         logic [NBUF-1:0]            seen;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < NBUF; i++) age_q[i] <= IDX_W'(NBUF - 1 - i);
            end else if (touch) begin
               for (int i = 0; i < NBUF; i++) begin
                  if (IDX_W'(i) == touch_idx)
                     age_q[i] <= '0;
                  else if (age_q[i] < age_q[touch_idx])
                     age_q[i] <= age_q[i] + 1'b1;
               end
            end
         end

         always_comb begin
            lru_idx = '0;
            for (int i = 0; i < NBUF; i++)
               if (age_q[i] == IDX_W'(NBUF - 1)) lru_idx = IDX_W'(i);
         end

         always_comb begin
            seen = '0;
            for (int i = 0; i < NBUF; i++) seen[age_q[i]] = 1'b1;
         end

         assert_age_perm_R4: assert property (@(posedge clk) disable iff (!rst_n)
            &seen);
         assert_touch_mru_R6: assert property (@(posedge clk) disable iff (!rst_n)
            touch |=> age_q[$past(touch_idx)] == '0);
      end else begin : g_nolru
         assign lru_idx = next_q;
      end
   endgenerate

   assign victim = two_mode ? next_q : lru_idx;

   assert_alternate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_done && two_mode) |=> (!two_mode || victim != $past(fill_idx)));
endmodule

// File: rtl/fpb_lines.sv
module fpb_lines #(
   parameter int NBUF   = 4,
   parameter int LINE_W = 256,
   parameter int TAG_W  = 19,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [NBUF-1:0]   en_mask,
   input  logic [TAG_W-1:0]  look_tag,
   input  logic              inv_we,
   input  logic [IDX_W-1:0]  inv_idx,
   input  logic              fill_we,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [LINE_W-1:0] fill_data,
   output logic              hit,
   output logic [IDX_W-1:0]  hit_idx,
   output logic [LINE_W-1:0] hit_line
);
   logic [NBUF-1:0]   valid_q;
   logic [TAG_W-1:0]  tag_q  [NBUF];
   logic [LINE_W-1:0] data_q [NBUF];
   logic [NBUF-1:0]   match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else begin
         for (int i = 0; i < NBUF; i++) begin
            if (flush)                                 valid_q[i] <= 1'b0;
            else if (inv_we && inv_idx == IDX_W'(i))   valid_q[i] <= 1'b0;
            else if (fill_we && fill_idx == IDX_W'(i)) valid_q[i] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_we) begin
         tag_q[fill_idx]  <= fill_tag;
         data_q[fill_idx] <= fill_data;
      end
   end

   always_comb begin
      hit_line = '0;
      hit_idx  = '0;
      for (int i = 0; i < NBUF; i++) begin
         match[i] = valid_q[i] && en_mask[i] && (tag_q[i] == look_tag);
         if (match[i]) begin
            hit_line = hit_line | data_q[i];
            hit_idx  = IDX_W'(i);
         end
      end
      hit = |match;
   end

   assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));
   assert_inv_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_we && !flush) |=> !valid_q[$past(inv_idx)]);
   assert_fill_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_we && !flush) |=> valid_q[$past(fill_idx)]);
   assert_flush_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> valid_q == '0);
endmodule

// File: rtl/flash_prefetch_buf.sv
module flash_prefetch_buf
   import fpb_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int WORD_W     = 32,
   parameter int LINE_WORDS = 8,
   parameter int NBUF       = 4,
   parameter int NBUF_SMALL = 2,
   parameter int WS_W       = 4,
   parameter int WS_RESET   = 5,
   localparam int LINE_W    = WORD_W * LINE_WORDS,
   localparam int BYTE_OFF  = $clog2(WORD_W / 8),
   localparam int WSEL_W    = $clog2(LINE_WORDS),
   localparam int TAG_W     = ADDR_W - BYTE_OFF - WSEL_W,
   localparam int IDX_W     = $clog2(NBUF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_req,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              fetch_rdy,
   output logic [WORD_W-1:0] fetch_data,
   output logic              flash_rd_en,
   output logic [TAG_W-1:0]  flash_rd_line,
   input  logic [LINE_W-1:0] flash_rd_data,
   input  logic              cfg_two_buf,
   input  logic              ws_wr,
   input  logic [WS_W-1:0]   ws_wdata,
   input  logic              ws_upd
);
   initial begin
      if (NBUF < 2 || (1 << IDX_W) != NBUF)
         $fatal(1, "NBUF must be a power of two of at least 2");
      if (NBUF_SMALL < 1 || NBUF_SMALL > NBUF)
         $fatal(1, "NBUF_SMALL must lie within 1..NBUF");
      if ((1 << WSEL_W) != LINE_WORDS || TAG_W < 1)
         $fatal(1, "line geometry does not fit the address width");
   end

   fpb_state_e       state_q;
   logic [WS_W-1:0]  cnt_q, fill_ws_q, ws_act;
   logic [TAG_W-1:0] fill_tag_q;
   logic [IDX_W-1:0] fill_idx_q, victim, hit_idx;
   logic             mode_q, flush, hit, miss, last_fill;
   logic [NBUF-1:0]  en_mask;
   logic [LINE_W-1:0] hit_line;
   logic [TAG_W-1:0]  req_tag;
   logic [WSEL_W-1:0] req_word;

   assign req_tag  = fetch_addr[ADDR_W-1 -: TAG_W];
   assign req_word = fetch_addr[BYTE_OFF +: WSEL_W];
   assign flush    = (mode_q != cfg_two_buf);

   generate
      for (genvar g = 0; g < NBUF; g++) begin : g_en
         assign en_mask[g] = cfg_two_buf ? (g < NBUF_SMALL) : 1'b1;
      end
   endgenerate

   fpb_ws_shadow #(.WS_W(WS_W), .WS_RESET(WS_RESET)) u_ws (
      .clk(clk), .rst_n(rst_n), .ws_wr(ws_wr), .ws_wdata(ws_wdata),
      .ws_upd(ws_upd), .ws_act(ws_act));

   fpb_lines #(.NBUF(NBUF), .LINE_W(LINE_W), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_lines (
      .clk(clk), .rst_n(rst_n), .flush(flush), .en_mask(en_mask),
      .look_tag(req_tag), .inv_we(miss), .inv_idx(victim),
      .fill_we(last_fill), .fill_idx(fill_idx_q), .fill_tag(fill_tag_q),
      .fill_data(flash_rd_data), .hit(hit), .hit_idx(hit_idx), .hit_line(hit_line));

   fpb_replace #(.NBUF(NBUF), .NBUF_SMALL(NBUF_SMALL), .IDX_W(IDX_W)) u_repl (
      .clk(clk), .rst_n(rst_n), .two_mode(cfg_two_buf),
      .touch(fetch_rdy), .touch_idx(hit_idx),
      .fill_done(last_fill), .fill_idx(fill_idx_q), .victim(victim));

   assign miss      = (state_q == FPB_IDLE) && fetch_req && !hit;
   assign last_fill = (state_q == FPB_FILL) && (cnt_q == fill_ws_q);
   assign fetch_rdy = (state_q == FPB_IDLE) && fetch_req && hit;
   assign fetch_data    = hit_line[req_word * WORD_W +: WORD_W];
   assign flash_rd_en   = (state_q == FPB_FILL);
   assign flash_rd_line = fill_tag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= FPB_IDLE;
         cnt_q      <= '0;
         fill_ws_q  <= '0;
         fill_tag_q <= '0;
         fill_idx_q <= '0;
         mode_q     <= 1'b0;
      end else begin
         mode_q <= cfg_two_buf;
         case (state_q)
            FPB_IDLE: if (miss) begin
               state_q    <= FPB_FILL;
               cnt_q      <= '0;
               fill_ws_q  <= ws_act;
               fill_tag_q <= req_tag;
               fill_idx_q <= victim;
            end
            FPB_FILL: begin
               if (last_fill) state_q <= FPB_IDLE;
               else           cnt_q   <= cnt_q + 1'b1;
            end
            default: state_q <= FPB_IDLE;
         endcase
      end
   end

   assert_miss_reads_R3: assert property (@(posedge clk) disable iff (!rst_n)
      miss |=> flash_rd_en && flash_rd_line == $past(req_tag));
   assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      flash_rd_en |-> !fetch_rdy);
   assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !fetch_rdy) |=> fetch_req && $stable(fetch_addr));
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_req |-> !fetch_rdy);
endmodule

// File: tb/sim_flash_prefetch_buf.sv
module sim_flash_prefetch_buf;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         fetch_req = 1'b0;
   logic [23:0]  fetch_addr = '0;
   logic         fetch_rdy;
   logic [31:0]  fetch_data;
   logic         flash_rd_en;
   logic [18:0]  flash_rd_line;
   logic [255:0] flash_rd_data;
   logic         cfg_two_buf = 1'b0;
   logic         ws_wr = 1'b0;
   logic [3:0]   ws_wdata = '0;
   logic         ws_upd = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   int ws_model = 5;

   always #(CLK_PERIOD / 2) clk = ~clk;

   flash_prefetch_buf u0 (
      .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .fetch_rdy(fetch_rdy), .fetch_data(fetch_data), .flash_rd_en(flash_rd_en),
      .flash_rd_line(flash_rd_line), .flash_rd_data(flash_rd_data),
      .cfg_two_buf(cfg_two_buf), .ws_wr(ws_wr), .ws_wdata(ws_wdata), .ws_upd(ws_upd));

   function automatic logic [31:0] mkword(input logic [18:0] line, input int w);
      return {line, 5'(w), 8'h5A};
   endfunction

   function automatic logic [23:0] mkaddr(input logic [18:0] line, input int w);
      return {line, 3'(w), 2'b00};
   endfunction

   // behavioural flash: line content derived from its address
   always_comb begin
      for (int w = 0; w < 8; w++) flash_rd_data[w*32 +: 32] = mkword(flash_rd_line, w);
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   // one fetch; expect_hit selects zero latency or a full refill
   task automatic fetch(input logic [18:0] line, input int w, input bit expect_hit, input string req);
      int lat = 0;
      int rd = 0;
      bit badl = 0;
      int exp_lat;
      logic [31:0] got;
      @(negedge clk);
      fetch_req  = 1'b1;
      fetch_addr = mkaddr(line, w);
      #1;
      while (!fetch_rdy && lat < 64) begin
         if (flash_rd_en) begin
            rd++;
            if (flash_rd_line != line) badl = 1;
         end
         @(negedge clk);
         #1;
         lat++;
      end
      got = fetch_data;
      @(posedge clk);
      #1;
      fetch_req = 1'b0;
      exp_lat = expect_hit ? 0 : ws_model + 2;
      chk(lat == exp_lat, {req, " latency"}, lat, exp_lat);
      chk(got == mkword(line, w), {req, " data"}, int'(got), int'(mkword(line, w)));
      if (!expect_hit) begin
         chk(rd == ws_model + 1 && !badl, {req, " read strobe"}, rd, ws_model + 1);
      end
   endtask

   task automatic set_mode(input bit two);
      @(negedge clk);
      cfg_two_buf = two;
   endtask

   task automatic ws_cmd(input bit wr, input logic [3:0] val, input bit upd);
      @(negedge clk);
      ws_wr = wr; ws_wdata = val; ws_upd = upd;
      @(negedge clk);
      ws_wr = 1'b0; ws_upd = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      #1;
      chk(!fetch_rdy && !flash_rd_en, "R1 idle outputs", {fetch_rdy, flash_rd_en}, 0);
      fetch(19'h00010, 3, 1'b0, "R1 first fetch misses with 5 wait states");
   endtask

   task automatic t_words();
      fetch(19'h00123, 0, 1'b0, "R3 refill");
      for (int w = 0; w < 8; w++) fetch(19'h00123, w, 1'b1, "R2 hit word select");
   endtask

   task automatic t_lru();
      fetch(19'h0A000, 1, 1'b0, "R4 fill A");
      fetch(19'h0B000, 1, 1'b0, "R4 fill B");
      fetch(19'h0C000, 1, 1'b0, "R4 fill C");
      fetch(19'h0D000, 1, 1'b0, "R4 fill D");
      fetch(19'h0A000, 2, 1'b1, "R6 hit A");
      fetch(19'h0E000, 1, 1'b0, "R4 fill E evicts B");
      fetch(19'h0A000, 4, 1'b1, "R6 A kept after hit");
      fetch(19'h0C000, 4, 1'b1, "R4 C kept");
      fetch(19'h0D000, 4, 1'b1, "R4 D kept");
      fetch(19'h0E000, 4, 1'b1, "R6 refilled E hits");
      fetch(19'h0B000, 4, 1'b0, "R4 B was the victim");
   endtask

   task automatic t_ws();
      ws_cmd(1'b1, 4'd2, 1'b0);
      fetch(19'h11000, 0, 1'b0, "R7 pending value not yet active");
      ws_cmd(1'b0, 4'd0, 1'b1);
      ws_model = 2;
      fetch(19'h12000, 0, 1'b0, "R7 updated to 2");
      ws_cmd(1'b1, 4'd3, 1'b1);
      fetch(19'h13000, 0, 1'b0, "R7 same-cycle write keeps old pending");
      ws_cmd(1'b0, 4'd0, 1'b1);
      ws_model = 3;
      fetch(19'h14000, 0, 1'b0, "R7 updated to 3");
      ws_cmd(1'b1, 4'd5, 1'b0);
      ws_cmd(1'b0, 4'd0, 1'b1);
      ws_model = 5;
   endtask

   task automatic t_pingpong();
      set_mode(1'b1);
      fetch(19'h21000, 0, 1'b0, "R5 fill L1");
      fetch(19'h22000, 0, 1'b0, "R5 fill L2");
      fetch(19'h21000, 1, 1'b1, "R5 hit L1");
      fetch(19'h23000, 0, 1'b0, "R5 fill L3 overwrites L1");
      fetch(19'h21000, 2, 1'b0, "R5 L1 gone despite recent hit");
      fetch(19'h23000, 2, 1'b1, "R5 L3 kept");
      fetch(19'h22000, 2, 1'b0, "R5 L2 replaced by L1");
   endtask

   task automatic t_flush();
      fetch(19'h23000, 5, 1'b0, "R5 L3 replaced by L2");
      fetch(19'h23000, 6, 1'b1, "R8 cached before flip");
      set_mode(1'b0);
      fetch(19'h23000, 6, 1'b0, "R8 flip two->four invalidates");
      fetch(19'h23000, 7, 1'b1, "R8 refetched");
      set_mode(1'b1);
      fetch(19'h23000, 7, 1'b0, "R8 flip four->two invalidates");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=expired expected=done");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_words();
      t_lru();
      t_ws();
      t_pingpong();
      t_flush();
      repeat (2) @(negedge clk);
      summary();
   end
endmodule